// File: doc/BRIEF.md
# Read-After-Write Interlock for a Five-Stage In-Order Pipeline

This block keeps the front of a five-stage in-order pipeline (fetch, decode with register read, execute, memory, write-back) from reading a register too early. The pipeline has no bypass paths. The block looks at the source register numbers that the instruction in decode wants to read and compares them with the destinations of older instructions that have not yet written their results. On a match it freezes the program counter and the fetch/decode register and sends a bubble into execute instead of the dependent instruction.

The block keeps its own copy of the destination tag (valid, write-enable, register number) for each instruction in execute, memory and write-back. It fills this copy from the decode slot each cycle. A bubble clears both the valid bit and the write-enable.

Operands are always read in decode and results are always written in write-back. Because of this fixed timing, writes always land in program order, so only read-after-write dependences are checked. Register 0 always reads as zero and never creates a dependence. The register file writes in the first half of a cycle and reads in the second half, so a producer in write-back never blocks a reader.

Top module: `raw_interlock`

## Requirements
- R1: A valid decode instruction whose enabled, nonzero source equals the destination of a valid, writing instruction in execute raises `stall_front` in that same cycle.
- R2: The same match against a valid, writing instruction in memory also raises `stall_front` in that same cycle.
- R3: A match against an instruction in write-back never raises `stall_front`.
- R4: Source register 0 never causes a stall, even if an older instruction names register 0 as a writing destination.
- R5: A producer with write-enable low never causes a stall (stores, branches). A source whose read-enable is low never causes a stall.
- R6: `bubble_idex` is high exactly when `stall_front` is high. In the cycle after a stall, `idex_valid` and `idex_we` are both 0.
- R7: In the cycle after a cycle with no stall, `idex_valid` equals the previous `dec_valid`, and `idex_we` equals the previous `dec_valid && dec_rd_we`. For a valid instruction, `idex_rd` equals its `dec_rd`.
- R8: If a consumer directly follows its producer, it stalls for 2 cycles. With one instruction between them it stalls for 1 cycle. With two or more between them it does not stall. Stall runs never exceed 2 cycles. Independent instructions never stall.
- R9: While `rst_n` is low at a clock edge, all tracked stages are cleared. After reset, `idex_valid` and `idex_we` are 0.
- R10: An empty decode slot (`dec_valid` low) never stalls and enters execute as an empty slot. An empty slot between a producer and its consumer counts as one intervening instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dec_valid | input | 1 | Decode slot holds an instruction |
| dec_src | input | NUM_SRC*REG_AW | Source register numbers; source k sits at bits [k*REG_AW +: REG_AW] |
| dec_src_en | input | NUM_SRC | Read-enable per source |
| dec_rd | input | REG_AW | Destination register of the decode instruction |
| dec_rd_we | input | 1 | Decode instruction writes `dec_rd` |
| stall_front | output | 1 | Hold the PC and the fetch/decode register |
| bubble_idex | output | 1 | Load an empty slot into the decode/execute register |
| idex_valid | output | 1 | Tracked valid bit of the instruction now in execute |
| idex_we | output | 1 | Tracked write-enable of the instruction now in execute |
| idex_rd | output | REG_AW | Tracked destination of the instruction now in execute |

## Verification
`stall_front` and `bubble_idex` are combinational, so the bench reads them in the same cycle that the decode inputs are applied. It drives inputs on the falling edge and samples just after it. The execute-stage tag is registered and changes only on the next rising edge. The monitor therefore compares it, one sample later, against what the previous cycle did: accepted an instruction, stalled, or sat idle. The stall count for each issued instruction is queued by the driver before the instruction is applied. The monitor compares that count when the instruction is finally accepted.

// File: rtl/raw_pkg.sv
// Shared constants and helpers for the read-after-write interlock.
// Assumes stage index 0 is execute and the last index is write-back.
package raw_pkg;

    // Tracked stages behind decode: execute, memory, write-back.
    localparam int unsigned TRACK_DEPTH_DEF = 3;
    localparam int unsigned REG_AW_DEF      = 5;

    // True when a producer sitting in stage idx can still block a reader.
    function automatic bit stage_blocks(input int idx, input int depth, input bit wb_split);
        if (idx < depth - 1) return 1'b1;
        return !wb_split;
    endfunction

endpackage

// File: rtl/raw_tag_pipe.sv
// Destination-tag shadow of the stages behind decode.
// Assumes the core advances every cycle; a stall only replaces the
// decode-to-execute transfer with an empty slot.
module raw_tag_pipe #(
    parameter int unsigned AW    = 5,
    parameter int unsigned DEPTH = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic                in_we,
    input  logic [AW-1:0]       in_rd,
    input  logic                bubble,
    output logic [DEPTH-1:0]    stg_valid,
    output logic [DEPTH-1:0]    stg_we,
    output logic [DEPTH*AW-1:0] stg_rd
);

    logic [DEPTH-1:0]    v_q;
    logic [DEPTH-1:0]    we_q;
    logic [DEPTH*AW-1:0] rd_q;

    // Execute-stage tag: load the decode tag, or an empty slot on a bubble.
    always_ff @(posedge clk) begin
        if (!rst_n || bubble || !in_valid) begin
            v_q[0]       <= 1'b0;
            we_q[0]      <= 1'b0;
            rd_q[AW-1:0] <= '0;
        end else begin
            v_q[0]       <= 1'b1;
            we_q[0]      <= in_we;
            rd_q[AW-1:0] <= in_rd;
        end
    end

    for (genvar i = 1; i < DEPTH; i++) begin : g_stage
        // Later stages: shift the older tag forward one stage.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q[i]            <= 1'b0;
                we_q[i]           <= 1'b0;
                rd_q[i*AW +: AW]  <= '0;
            end else begin
                v_q[i]            <= v_q[i-1];
                we_q[i]           <= we_q[i-1];
                rd_q[i*AW +: AW]  <= rd_q[(i-1)*AW +: AW];
            end
        end
    end

    assign stg_valid = v_q;
    assign stg_we    = we_q;
    assign stg_rd    = rd_q;

endmodule

// File: rtl/raw_src_match.sv
// Compares one decode source against every tracked producer tag.
// Assumes register 0 is constant zero. When WB_SPLIT is set, the
// write-back stage is skipped (write in the first half, read in the second).
module raw_src_match
    import raw_pkg::*;
#(
    parameter int unsigned AW       = 5,
    parameter int unsigned DEPTH    = 3,
    parameter bit          WB_SPLIT = 1'b1
) (
    input  logic [AW-1:0]       src,
    input  logic                src_en,
    input  logic [DEPTH-1:0]    stg_valid,
    input  logic [DEPTH-1:0]    stg_we,
    input  logic [DEPTH*AW-1:0] stg_rd,
    output logic                hit
);

    logic [DEPTH-1:0] stage_hit;
    logic             src_live;

    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        if (stage_blocks(i, DEPTH, WB_SPLIT)) begin : g_live
            assign stage_hit[i] = stg_valid[i] && stg_we[i] && (stg_rd[i*AW +: AW] == src);
        end else begin : g_skip
            assign stage_hit[i] = 1'b0;
        end
    end

    // A source only counts when it is read and is not the zero register.
    always_comb src_live = src_en && (src != '0);

    assign hit = src_live && (|stage_hit);

endmodule

// File: rtl/raw_interlock.sv
// Read-after-write interlock for a five-stage in-order pipeline without bypass.
// Assumes fixed read (decode) and write (write-back) stages, so only
// read-after-write is checked. The stall holds PC and fetch/decode; the bubble
// empties the decode/execute slot.
module raw_interlock
    import raw_pkg::*;
#(
    parameter int unsigned REG_AW      = REG_AW_DEF,
    parameter int unsigned NUM_SRC     = 2,
    parameter int unsigned TRACK_DEPTH = TRACK_DEPTH_DEF,
    parameter bit          WB_SPLIT    = 1'b1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      dec_valid,
    input  logic [NUM_SRC*REG_AW-1:0] dec_src,
    input  logic [NUM_SRC-1:0]        dec_src_en,
    input  logic [REG_AW-1:0]         dec_rd,
    input  logic                      dec_rd_we,
    output logic                      stall_front,
    output logic                      bubble_idex,
    output logic                      idex_valid,
    output logic                      idex_we,
    output logic [REG_AW-1:0]         idex_rd
);

    localparam int unsigned TAG_RD_W = TRACK_DEPTH * REG_AW;

    logic [TRACK_DEPTH-1:0] stg_valid;
    logic [TRACK_DEPTH-1:0] stg_we;
    logic [TAG_RD_W-1:0]    stg_rd;
    logic [NUM_SRC-1:0]     src_hit;
    logic                   hold;

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
        raw_src_match #(
            .AW       (REG_AW),
            .DEPTH    (TRACK_DEPTH),
            .WB_SPLIT (WB_SPLIT)
        ) u_match (
            .src       (dec_src[k*REG_AW +: REG_AW]),
            .src_en    (dec_src_en[k]),
            .stg_valid (stg_valid),
            .stg_we    (stg_we),
            .stg_rd    (stg_rd),
            .hit       (src_hit[k])
        );
    end

    // Stall only for an occupied decode slot with at least one hit.
    always_comb hold = dec_valid && (|src_hit);

    raw_tag_pipe #(
        .AW    (REG_AW),
        .DEPTH (TRACK_DEPTH)
    ) u_tags (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (dec_valid),
        .in_we     (dec_rd_we),
        .in_rd     (dec_rd),
        .bubble    (hold),
        .stg_valid (stg_valid),
        .stg_we    (stg_we),
        .stg_rd    (stg_rd)
    );

    assign stall_front = hold;
    assign bubble_idex = hold;
    assign idex_valid  = stg_valid[0];
    assign idex_we     = stg_we[0];
    assign idex_rd     = stg_rd[REG_AW-1:0];

endmodule

// File: rtl/raw_interlock_chk.sv
// Assertion checker for raw_interlock, attached by bind below.
// Assumes the same parameters as the bound instance.
module raw_interlock_chk #(
    parameter int unsigned REG_AW  = 5,
    parameter int unsigned NUM_SRC = 2
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      dec_valid,
    input logic [NUM_SRC*REG_AW-1:0] dec_src,
    input logic [NUM_SRC-1:0]        dec_src_en,
    input logic [REG_AW-1:0]         dec_rd,
    input logic                      dec_rd_we,
    input logic                      stall_front,
    input logic                      bubble_idex,
    input logic                      idex_valid,
    input logic                      idex_we,
    input logic [REG_AW-1:0]         idex_rd
);

    logic any_live_src;

    // Is any enabled, nonzero source present in decode?
    always_comb begin
        any_live_src = 1'b0;
        for (int k = 0; k < NUM_SRC; k++)
            if (dec_src_en[k] && dec_src[k*REG_AW +: REG_AW] != '0) any_live_src = 1'b1;
    end

    // R4
    stall_needs_live_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall_front |-> any_live_src);

    // R6
    bubble_empties_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bubble_idex |=> (!idex_valid && !idex_we));

    // R6
    bubble_with_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bubble_idex == stall_front);

    // R7
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stall_front |=> (idex_valid == $past(dec_valid))
                      && (idex_we == $past(dec_valid && dec_rd_we))
                      && (!$past(dec_valid) || idex_rd == $past(dec_rd)));

    // R8
    stall_run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_front && $past(stall_front)) |=> !stall_front);

    // R9
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (!idex_valid && !idex_we));

    // R10
    empty_slot_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> !stall_front);

endmodule

bind raw_interlock raw_interlock_chk #(
    .REG_AW  (REG_AW),
    .NUM_SRC (NUM_SRC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dec_valid   (dec_valid),
    .dec_src     (dec_src),
    .dec_src_en  (dec_src_en),
    .dec_rd      (dec_rd),
    .dec_rd_we   (dec_rd_we),
    .stall_front (stall_front),
    .bubble_idex (bubble_idex),
    .idex_valid  (idex_valid),
    .idex_we     (idex_we),
    .idex_rd     (idex_rd)
);

// File: tb/tb_raw_interlock.sv
// Scoreboard bench: the driver queues the expected stall count for each
// instruction; the monitor measures and compares once the instruction is accepted.
module tb_raw_interlock;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int AW = 5;
    localparam int NS = 2;

    typedef struct {
        int       stalls;
        logic [AW-1:0] rd;
        bit       we;
        string    req;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              dec_valid = 1'b0;
    logic [NS*AW-1:0]  dec_src = '0;
    logic [NS-1:0]     dec_src_en = '0;
    logic [AW-1:0]     dec_rd = '0;
    logic              dec_rd_we = 1'b0;
    logic              stall_front, bubble_idex, idex_valid, idex_we;
    logic [AW-1:0]     idex_rd;

    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;
    exp_t exp_q[$];

    always #2 clk = ~clk;

    raw_interlock dut (
        .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_src(dec_src),
        .dec_src_en(dec_src_en), .dec_rd(dec_rd), .dec_rd_we(dec_rd_we),
        .stall_front(stall_front), .bubble_idex(bubble_idex),
        .idex_valid(idex_valid), .idex_we(idex_we), .idex_rd(idex_rd)
    );

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Driver: queue the expectation, present the instruction, hold it while stalled.
    task automatic issue(input logic [AW-1:0] s1, input bit e1, input logic [AW-1:0] s2, input bit e2,
                         input logic [AW-1:0] rd, input bit we, input int stalls, input string req);
        exp_t e;
        e.stalls = stalls; e.rd = rd; e.we = we; e.req = req;
        exp_q.push_back(e);
        @(negedge clk);
        dec_valid = 1'b1; dec_src = {s2, s1}; dec_src_en = {e2, e1};
        dec_rd = rd; dec_rd_we = we;
        #0.5;
        while (stall_front) begin
            @(negedge clk);
            #0.5;
        end
        @(posedge clk);
        #0.5 dec_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            dec_valid = 1'b0;
        end
    endtask

    // Monitor: sample after each falling edge and check this cycle and the tag it follows.
    initial begin
        int  cnt = 0;
        int  prev_kind = 0;
        bit  prev_we = 1'b0;
        logic [AW-1:0] prev_rd = '0;
        exp_t e;
        forever begin
            @(negedge clk);
            #1;
            if (rst_n && !done) begin
                case (prev_kind)
                    1: check(!idex_valid && !idex_we, "R6", "slot after stall empty", int'({idex_valid, idex_we}), 0);
                    2: begin
                        check(idex_valid && idex_we == prev_we, "R7", "tag valid/we", int'({idex_valid, idex_we}), int'({1'b1, prev_we}));
                        check(idex_rd == prev_rd, "R7", "tag rd", int'(idex_rd), int'(prev_rd));
                    end
                    default: check(!idex_valid, "R10", "empty slot enters execute", int'(idex_valid), 0);
                endcase
                if (dec_valid) begin
                    check(bubble_idex == stall_front, "R6", "bubble equals stall", int'(bubble_idex), int'(stall_front));
                    if (stall_front) begin
                        cnt++;
                        prev_kind = 1;
                    end else if (exp_q.size() == 0) begin
                        check(1'b0, "R8", "unexpected accept", 1, 0);
                        prev_kind = 2;
                    end else begin
                        e = exp_q.pop_front();
                        check(cnt == e.stalls, e.req, "stall cycles", cnt, e.stalls);
                        cnt = 0;
                        prev_kind = 2; prev_we = e.we; prev_rd = e.rd;
                    end
                end else begin
                    check(!stall_front, "R10", "no stall on empty slot", int'(stall_front), 0);
                    prev_kind = 0;
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            check(1'b0, "R8", "watchdog expired", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #0.5;
        // R9: tags cleared during reset
        check(!idex_valid && !idex_we, "R9", "execute tag in reset", int'({idex_valid, idex_we}), 0);
        check(!stall_front, "R9", "no stall in reset", int'(stall_front), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 R8: load r1 then direct consumer -> 2 stalls
        issue(5'd30, 1, 5'd31, 0, 5'd1, 1, 0, "R8");
        issue(5'd1, 1, 5'd31, 1, 5'd3, 1, 2, "R1");
        idle(3);

        // R2: one independent instruction between -> 1 stall via source 2
        issue(5'd30, 1, 5'd0, 0, 5'd4, 1, 0, "R8");
        issue(5'd6, 1, 5'd7, 1, 5'd5, 1, 0, "R8");
        issue(5'd31, 1, 5'd4, 1, 5'd8, 1, 1, "R2");
        idle(3);

        // R3: producer in write-back does not block
        issue(5'd30, 1, 5'd0, 0, 5'd9, 1, 0, "R8");
        issue(5'd30, 1, 5'd0, 0, 5'd12, 1, 0, "R8");
        issue(5'd30, 1, 5'd0, 0, 5'd13, 1, 0, "R8");
        issue(5'd9, 1, 5'd0, 0, 5'd14, 1, 0, "R3");
        idle(3);

        // R4: register 0 never matches
        issue(5'd30, 1, 5'd0, 0, 5'd0, 1, 0, "R4");
        issue(5'd0, 1, 5'd0, 1, 5'd15, 1, 0, "R4");
        idle(3);

        // R5: non-writing producer and disabled sources
        issue(5'd30, 1, 5'd31, 1, 5'd10, 0, 0, "R5");
        issue(5'd10, 1, 5'd0, 0, 5'd16, 1, 0, "R5");
        issue(5'd30, 1, 5'd0, 0, 5'd11, 1, 0, "R5");
        issue(5'd11, 0, 5'd11, 0, 5'd17, 1, 0, "R5");
        idle(3);

        // R1: direct consumer on source 2
        issue(5'd30, 1, 5'd0, 0, 5'd18, 1, 0, "R8");
        issue(5'd31, 1, 5'd18, 1, 5'd19, 1, 2, "R1");
        idle(3);

        // R10: an empty slot between producer and consumer -> 1 stall
        issue(5'd30, 1, 5'd0, 0, 5'd20, 1, 0, "R10");
        idle(1);
        issue(5'd20, 1, 5'd0, 0, 5'd24, 1, 1, "R10");
        idle(3);

        // R8: dependent chain, each link stalls twice
        issue(5'd30, 1, 5'd0, 0, 5'd21, 1, 0, "R8");
        issue(5'd21, 1, 5'd0, 0, 5'd22, 1, 2, "R8");
        issue(5'd22, 1, 5'd21, 1, 5'd23, 1, 2, "R8");
        idle(3);

        // R8: independent stream never stalls
        for (int i = 0; i < 5; i++)
            issue(5'd30, 1, 5'd31, 1, 5'(25 + i), 1, 0, "R8");
        idle(3);

        check(exp_q.size() == 0, "R8", "pending expectations", exp_q.size(), 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule